// File: doc/BRIEF.md
# Sign-Aware Leading-Digit Normalization Encoder

This block finds how far a mantissa must be shifted left so that its first significant digit lands in the most significant bit position. It accepts a mantissa word and a sign bit and returns a shift count sized to drive the count input of a left shifter directly. With that shifter set for zero fill, the mantissa is normalized in a single pass.

Sign-magnitude and two's complement mantissas are both supported. Each mantissa bit is exclusive-ORed with the sign before the search. For a negative two's complement value, this turns the first zero below the run of leading ones into a leading one. The conditioning acts only on the search path. The mantissa handed on for shifting is the raw input word. When no bit is significant after conditioning, a separate flag is raised and the count saturates at its all-ones value.

The search is a balanced tree of two-input leading-zero merge nodes, so its depth grows with the logarithm of the word width. Count, flag and the raw mantissa are captured together in one output register. Results therefore appear one clock after a qualified input and are held while no new input is offered.

Top module: `lzn_norm_encoder`

## Requirements
- R1: For each accepted input, out_count equals the number of bit positions between bit MANT_W-1 and the highest bit i for which in_mant[i] XOR in_sign is 1, that is MANT_W-1-i.
- R2: An input whose bit MANT_W-1 is significant (in_mant[MANT_W-1] differs from in_sign) produces out_count 0 with out_none low.
- R3: An input whose only significant bit is bit 0 produces out_count MANT_W-1 (31 by default) with out_none low.
- R4: out_none is 1 exactly when every bit of in_mant equals in_sign, and in that case out_count is MANT_W-1. Otherwise out_none is 0.
- R5: With in_sign at 1, the search treats every bit inverted. For example, 0xFFFF0000 with sign 1 gives count 16, and 0x00000001 with sign 1 gives count 0.
- R6: out_mant carries the raw in_mant of the accepted input, whatever the value of in_sign.
- R7: out_valid is in_valid delayed by one clock. When in_valid is low, out_count, out_none and out_mant keep their previous values.
- R8: A synchronous active-low reset clears out_valid, out_count, out_none and out_mant to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_mant and in_sign for capture on this edge |
| in_mant | input | MANT_W (32) | Mantissa word to examine |
| in_sign | input | 1 | Sign of the mantissa; 1 inverts the search view |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| out_mant | output | MANT_W (32) | Raw mantissa, passed through for the shifter |
| out_count | output | $clog2(MANT_W) (5) | Left-shift count that normalizes the mantissa |
| out_none | output | 1 | No significant bit found in the conditioned word |

## Verification
The bench sweeps a single significant bit across every position under both sign values, because a tree node that is wired to the wrong half or has a flipped select bit gives a wrong count only at certain positions. It also drives the four words that are all-zero or all-one under each sign. A design that conditions on the wrong polarity, or forgets to saturate, reports a count of 0 or 32-wrapped values with the flag low instead of 31 with the flag high. Random words, shifted right by random amounts, spread the counts across the full range. The bench checks that the raw mantissa never arrives inverted when the sign is set. Idle stretches with changing inputs confirm that the outputs are held and not reloaded.

// File: rtl/lzn_pkg.sv
// Package: shared constants and offset helpers for the normalization encoder.
// Assumes the mantissa width is a power of two, at least 2.
package lzn_pkg;

    localparam int MANT_W_DEF = 32;

    // Number of merge nodes at tree level lvl (level 1 = leaf pairs).
    function automatic int lvl_nodes(input int w, input int lvl);
        return w >> lvl;
    endfunction

    // Bit offset of level lvl inside the flattened node-valid vector.
    function automatic int v_off(input int w, input int lvl);
        int acc;
        acc = 0;
        for (int k = 1; k < lvl; k++) acc += (w >> k);
        return acc;
    endfunction

    // Bit offset of level lvl inside the flattened node-count vector;
    // nodes of level k carry k count bits.
    function automatic int c_off(input int w, input int lvl);
        int acc;
        acc = 0;
        for (int k = 1; k < lvl; k++) acc += (w >> k) * k;
        return acc;
    endfunction

endpackage

// File: rtl/lzn_condition.sv
// Module: lzn_condition
// Conditions the mantissa for the search by XOR with the sign, so that
// the first significant digit always shows up as a 1. Purely combinational;
// the raw word is not touched here and is routed separately by the top.
module lzn_condition #(
    parameter int MANT_W = lzn_pkg::MANT_W_DEF
) (
    input  logic [MANT_W-1:0] raw_mant,
    input  logic              sign,
    output logic [MANT_W-1:0] cond_mant
);

    // One XOR per bit: invert every position when the sign is set.
    for (genvar b = 0; b < MANT_W; b++) begin : g_bit
        assign cond_mant[b] = raw_mant[b] ^ sign;
    end

endmodule

// File: rtl/lzn_lzc_tree.sv
// Module: lzn_lzc_tree
// Leading-zero counter built as a balanced tree of merge nodes.
// Level 1 looks at bit pairs; each higher level merges two neighbours,
// taking the left (more significant) count when the left half holds a one,
// otherwise the right count with the half-width bit set. With no one at all
// every select falls to the right and the count reads all ones.
// Assumes MANT_W is a power of two, at least 2. Combinational.
module lzn_lzc_tree #(
    parameter int MANT_W = lzn_pkg::MANT_W_DEF,
    localparam int CNT_W = $clog2(MANT_W)
) (
    input  logic [MANT_W-1:0] vec,
    output logic [CNT_W-1:0]  lz_count,
    output logic              all_zero
);

    localparam int V_TOT = lzn_pkg::v_off(MANT_W, CNT_W + 1);
    localparam int C_TOT = lzn_pkg::c_off(MANT_W, CNT_W + 1);

    logic [V_TOT-1:0] node_v;  // per-node "contains a one"
    logic [C_TOT-1:0] node_c;  // per-node leading-zero count

    // Leaf level: each node inspects one bit pair, node 0 being the top pair.
    for (genvar i = 0; i < MANT_W / 2; i++) begin : g_leaf
        localparam int VO = lzn_pkg::v_off(MANT_W, 1);
        localparam int CO = lzn_pkg::c_off(MANT_W, 1);
        assign node_v[VO + i] = vec[MANT_W-1-2*i] | vec[MANT_W-2-2*i];
        assign node_c[CO + i] = ~vec[MANT_W-1-2*i];
    end

    // Merge levels: node i of level L combines nodes 2i and 2i+1 of L-1.
    for (genvar L = 2; L <= CNT_W; L++) begin : g_lvl
        localparam int PV = lzn_pkg::v_off(MANT_W, L - 1);
        localparam int PC = lzn_pkg::c_off(MANT_W, L - 1);
        localparam int VO = lzn_pkg::v_off(MANT_W, L);
        localparam int CO = lzn_pkg::c_off(MANT_W, L);
        for (genvar i = 0; i < lzn_pkg::lvl_nodes(MANT_W, L); i++) begin : g_node
            logic         lv, rv;
            logic [L-2:0] lc, rc;
            assign lv = node_v[PV + 2*i];
            assign rv = node_v[PV + 2*i + 1];
            assign lc = node_c[PC + (2*i)*(L-1) +: L-1];
            assign rc = node_c[PC + (2*i+1)*(L-1) +: L-1];
            assign node_v[VO + i]      = lv | rv;
            assign node_c[CO + i*L +: L] = lv ? {1'b0, lc} : {1'b1, rc};
        end
    end

    assign lz_count = node_c[lzn_pkg::c_off(MANT_W, CNT_W) +: CNT_W];
    assign all_zero = ~node_v[lzn_pkg::v_off(MANT_W, CNT_W)];

endmodule

// File: rtl/lzn_out_reg.sv
// Module: lzn_out_reg
// Output stage: captures count, flag and raw mantissa together when the
// input is qualified, holds them otherwise. Synchronous active-low reset.
module lzn_out_reg #(
    parameter int MANT_W = lzn_pkg::MANT_W_DEF,
    localparam int CNT_W = $clog2(MANT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MANT_W-1:0] d_mant,
    input  logic [CNT_W-1:0]  d_count,
    input  logic              d_none,
    output logic              q_valid,
    output logic [MANT_W-1:0] q_mant,
    output logic [CNT_W-1:0]  q_count,
    output logic              q_none
);

    // Valid flag: follows the load strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end

    // Result payload: loaded on a qualified input, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_mant  <= '0;
            q_count <= '0;
            q_none  <= 1'b0;
        end else if (load) begin
            q_mant  <= d_mant;
            q_count <= d_count;
            q_none  <= d_none;
        end
    end

endmodule

// File: rtl/lzn_norm_encoder.sv
// Module: lzn_norm_encoder (top)
// Sign-aware leading-digit normalization encoder. Conditions the mantissa
// with the sign, searches it with a leading-zero tree and registers the
// count, the no-significant-bit flag and the untouched mantissa.
// Assumes MANT_W is a power of two; one cycle latency.
module lzn_norm_encoder #(
    parameter int MANT_W = lzn_pkg::MANT_W_DEF,
    localparam int CNT_W = $clog2(MANT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sign,
    output logic              out_valid,
    output logic [MANT_W-1:0] out_mant,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_none
);

    logic [MANT_W-1:0] cond_mant;
    logic [CNT_W-1:0]  lz_count;
    logic              all_zero;

    lzn_condition #(.MANT_W(MANT_W)) u_cond (
        .raw_mant  (in_mant),
        .sign      (in_sign),
        .cond_mant (cond_mant)
    );

    lzn_lzc_tree #(.MANT_W(MANT_W)) u_tree (
        .vec      (cond_mant),
        .lz_count (lz_count),
        .all_zero (all_zero)
    );

    lzn_out_reg #(.MANT_W(MANT_W)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d_mant  (in_mant),
        .d_count (lz_count),
        .d_none  (all_zero),
        .q_valid (out_valid),
        .q_mant  (out_mant),
        .q_count (out_count),
        .q_none  (out_none)
    );

endmodule

// File: rtl/lzn_norm_encoder_chk.sv
// Module: lzn_norm_encoder_chk
// Port-level checker for the encoder, attached by bind below.
module lzn_norm_encoder_chk #(
    parameter int MANT_W = lzn_pkg::MANT_W_DEF,
    localparam int CNT_W = $clog2(MANT_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [MANT_W-1:0] in_mant,
    input logic              in_sign,
    input logic              out_valid,
    input logic [MANT_W-1:0] out_mant,
    input logic [CNT_W-1:0]  out_count,
    input logic              out_none
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MANT_W - 1);

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_count) && $stable(out_none) && $stable(out_mant));

    p_raw_mant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_mant == $past(in_mant));

    p_top_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_mant[MANT_W-1] != in_sign) |=> out_count == '0 && !out_none);

    p_low_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_mant ^ {MANT_W{in_sign}}) == MANT_W'(1))
        |=> out_count == CNT_MAX && !out_none);

    p_none_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_none == ($past(in_mant) == {MANT_W{$past(in_sign)}}));

    p_none_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_none |-> out_count == CNT_MAX);

endmodule

bind lzn_norm_encoder lzn_norm_encoder_chk #(.MANT_W(MANT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mant   (in_mant),
    .in_sign   (in_sign),
    .out_valid (out_valid),
    .out_mant  (out_mant),
    .out_count (out_count),
    .out_none  (out_none)
);

// File: tb/sim_lzn_norm_encoder.sv
// Scoreboard bench for lzn_norm_encoder at the default 32-bit width.
module sim_lzn_norm_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WD_CYCLES  = 20000;

    typedef struct {
        logic [W-1:0] mant;
        logic [4:0]   cnt;
        logic         none;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_mant = '0;
    logic         in_sign = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_mant;
    logic [4:0]   out_count;
    logic         out_none;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    item_t last;
    bit    have_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lzn_norm_encoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mant   (in_mant),
        .in_sign   (in_sign),
        .out_valid (out_valid),
        .out_mant  (out_mant),
        .out_count (out_count),
        .out_none  (out_none)
    );

    // Reference: loop search for the highest bit differing from the sign.
    function automatic void ref_enc(input logic [W-1:0] m, input logic s,
                                    output logic [4:0] c, output logic n);
        n = 1'b1;
        c = 5'd31;
        for (int i = W - 1; i >= 0; i--) begin
            if (n && (m[i] ^ s)) begin
                c = 5'(W - 1 - i);
                n = 1'b0;
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Driver: present one qualified input and queue its expectation.
    task automatic send(input logic [W-1:0] m, input logic s, input string tag);
        item_t it;
        @(negedge clk);
        it.mant = m;
        it.tag  = tag;
        ref_enc(m, s, it.cnt, it.none);
        in_valid = 1'b1;
        in_mant  = m;
        in_sign  = s;
        sb_q.push_back(it);
    endtask

    // Idle cycles with changing, unqualified data.
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mant  = $urandom;
            in_sign  = 1'($urandom);
        end
    endtask

    // Monitor: compare each result against the scoreboard; check hold when idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected out_valid", W'(1), W'(0));
                end else begin
                    item_t e;
                    e = sb_q.pop_front();
                    check(out_count == e.cnt, {"R1/", e.tag}, "count",
                          W'(out_count), W'(e.cnt));
                    check(out_none == e.none, {"R4/", e.tag}, "none flag",
                          W'(out_none), W'(e.none));
                    check(out_mant == e.mant, "R6", "raw mantissa", out_mant, e.mant);
                    last = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check(out_count == last.cnt && out_none == last.none && out_mant == last.mant,
                      "R7", "hold while idle", out_mant, last.mant);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state after synchronous reset edges.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "reset out_valid", W'(out_valid), W'(0));
        check(out_count == '0,   "R8", "reset out_count", W'(out_count), W'(0));
        check(out_none == 1'b0,  "R8", "reset out_none", W'(out_none), W'(0));
        check(out_mant == '0,    "R8", "reset out_mant", out_mant, W'(0));
        rst_n = 1'b1;
        idle(2);

        // R2: top bit significant under both signs.
        send(32'h8000_0000, 1'b0, "R2");
        send(32'h7FFF_FFFF, 1'b1, "R2");
        // R3: only bit 0 significant under both signs.
        send(32'h0000_0001, 1'b0, "R3");
        send(32'hFFFF_FFFE, 1'b1, "R3");
        // R4: no significant bit, plus the opposite-sign all-equal words.
        send(32'h0000_0000, 1'b0, "R4");
        send(32'hFFFF_FFFF, 1'b1, "R4");
        send(32'hFFFF_FFFF, 1'b0, "R4");
        send(32'h0000_0000, 1'b1, "R4");
        // R5: sign-set examples with known counts 16 and 0.
        send(32'hFFFF_0000, 1'b1, "R5");
        send(32'h0000_0001, 1'b1, "R5");
        idle(3);

        // R1: one-hot and inverted one-hot sweeps under both signs.
        for (int k = 0; k < W; k++) begin
            send(W'(1) << k, 1'b0, "R1");
            send(~(W'(1) << k), 1'b1, "R5");
            send(W'(1) << k, 1'b1, "R5");
        end
        idle(2);

        // R1: random words shifted right by random amounts, mixed idles.
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] m;
            logic         s;
            s = 1'($urandom);
            m = W'($urandom) >> ($urandom % W);
            if (s) m = ~m;
            send(m, s, "R1");
            if ((k % 37) == 0) idle(2);
        end
        idle(4);

        check(sb_q.size() == 0, "R7", "results outstanding", W'(sb_q.size()), W'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule